// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that completes each instruction in a single clock. It runs eight instructions: register add, subtract, and, or and signed set-less-than, word load, word store, and branch-if-equal. The core keeps instructions and data apart. Instructions come from a read-only store whose contents are fixed by a parameter. Data sits in a separate read/write word memory, which a second parameter sets to its starting values on reset.

Inside the core are the program counter and a register file of thirty-two 32-bit registers. There is also an ALU, a sign extender for the 16-bit constant field, an adder for the sequential PC and one for the branch target, the multiplexers that pick the destination register, the second operand and the write-back source, and a combinational control decoder. The only inputs are a clock and an active-low reset. Debug outputs show the current PC and any register write that the current instruction commits at the next rising edge.

Top module: `rcore_top`

## Requirements
- R1: While reset is asserted, the PC reads 0 and no register write is reported. Reset is asserted asynchronously and released on the second rising edge after the reset input goes high. The instruction at address 0 then executes during the cycle that follows.
- R2: Each instruction takes one cycle. Unless a branch is taken, the PC after the instruction equals the PC before it plus 4.
- R3: R-type words have opcode 0x00, with sources in bits [25:21] and [20:16] and the destination in bits [15:11]. Function code 0x20 writes the sum, 0x22 the difference (first minus second), 0x24 the bitwise and, and 0x25 the bitwise or.
- R4: Function code 0x2A writes 1 when the first source is less than the second as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x23 loads a word. The byte address is the register in bits [25:21] plus the sign-extended constant in bits [15:0]. Address bits [5:2] select one of 16 data words, and the result goes to the register named in bits [20:16].
- R6: Opcode 0x2B stores the register in bits [20:16] at the address formed as in R5. A later load returns the stored value, and the store writes no register.
- R7: Opcode 0x04 compares its two source registers. When they are equal, the next PC is PC+4 plus the sign-extended constant times 4, so a negative constant branches backward. The branch writes no register and no memory.
- R8: When the two branch sources differ, the next PC is PC+4.
- R9: Register 0 always reads as zero. A write to it has no effect and is not reported on the debug outputs.
- R10: Any other opcode, and any other function code under opcode 0x00, writes no register and no memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Active-low reset, asynchronous assertion |
| dbg_pc_o | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en_o | output | 1 | A register write commits at the next rising edge |
| dbg_wr_idx_o | output | 5 | Destination register of that write |
| dbg_wr_data_o | output | 32 | Value being written |

## Verification
The core runs a single program whose operand values are chosen so that wrong behaviour gives a different result. For example, a negative value against a positive one makes signed and unsigned compares disagree, and and/or operands with partly overlapping bits separate those two functions. Loads run with a zero base, a non-zero base and a negative offset, and each shows up as a different data word. A store followed by a load of the same word checks the store path. Branches are tried equal and unequal, forward and backward, with poison instructions placed on the skipped addresses. A reset in the middle of the run then checks that execution restarts at address 0.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_AW = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT,
    ALU_XOR
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    mem_write;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/rcore_ctrl.sv
module rcore_ctrl
  import rcore_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] func_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o = '{reg_write: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0,
               wb_from_mem: 1'b0, mem_write: 1'b0, is_branch: 1'b0,
               alu_op: ALU_ADD};
    unique case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.dst_is_rd = 1'b1;
        ctrl_o.reg_write = 1'b1;
        case (func_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_write = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl_o.reg_write   = 1'b1;
        ctrl_o.b_is_imm    = 1'b1;
        ctrl_o.wb_from_mem = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.b_is_imm  = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.is_branch = 1'b1;
        ctrl_o.alu_op    = ALU_XOR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
(
  input  alu_op_e             op_i,
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  output logic [WORD_W-1:0]   res_o,
  output logic                zero_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = ($signed(a_i) < $signed(b_i)) ? WORD_W'(1) : '0;
      ALU_XOR: res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile
  import rcore_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [AW-1:0]     ra_idx_i,
  input  logic [AW-1:0]     rb_idx_i,
  output logic [WORD_W-1:0] ra_val_o,
  output logic [WORD_W-1:0] rb_val_o,
  input  logic              we_i,
  input  logic [AW-1:0]     w_idx_i,
  input  logic [WORD_W-1:0] w_val_i
);

  logic [WORD_W-1:0] regs_q [NREGS];

  // Entry 0 is never stored; its read port returns zero.
  generate
    for (genvar g = 1; g < NREGS; g++) begin : g_reg
      logic load_en;
      assign load_en = we_i && (w_idx_i == AW'(g));
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)     regs_q[g] <= '0;
        else if (load_en) regs_q[g] <= w_val_i;
      end
    end
  endgenerate
  assign regs_q[0] = '0;

  assign ra_val_o = regs_q[ra_idx_i];
  assign rb_val_o = regs_q[rb_idx_i];

endmodule

// File: rtl/rcore_dmem.sv
module rcore_dmem
  import rcore_pkg::*;
#(
  parameter int unsigned WORDS = 16,
  parameter logic [WORDS*WORD_W-1:0] INIT = '0,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              we_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] mem_q [WORDS];

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic load_en;
      assign load_en = we_i && (idx_i == AW'(g));
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)     mem_q[g] <= INIT[g*WORD_W +: WORD_W];
        else if (load_en) mem_q[g] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 32,
  parameter int unsigned DMEM_WORDS = 16,
  parameter logic [IMEM_WORDS*WORD_W-1:0] IMAGE     = '0,
  parameter logic [DMEM_WORDS*WORD_W-1:0] DATA_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  output logic [WORD_W-1:0] dbg_pc_o,
  output logic              dbg_wr_en_o,
  output logic [REG_AW-1:0] dbg_wr_idx_o,
  output logic [WORD_W-1:0] dbg_wr_data_o
);

  localparam int unsigned IAW = $clog2(IMEM_WORDS);
  localparam int unsigned DAW = $clog2(DMEM_WORDS);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // Program counter: next-state logic, then the register.
  logic [WORD_W-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic              br_taken;
  logic [WORD_W-1:0] imm_ext;

  assign pc_plus4  = pc_q + WORD_W'(4);
  assign br_target = pc_plus4 + {imm_ext[WORD_W-3:0], 2'b00};
  assign pc_d      = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  // Instruction store built from the image parameter.
  logic [WORD_W-1:0] rom [IMEM_WORDS];
  generate
    for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
      assign rom[g] = IMAGE[g*WORD_W +: WORD_W];
    end
  endgenerate

  logic [WORD_W-1:0] instr;
  logic [5:0]        opcode, func;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx;
  logic              unused_fields;

  assign instr   = rom[pc_q[IAW+1:2]];
  assign opcode  = instr[31:26];
  assign rs_idx  = instr[25:21];
  assign rt_idx  = instr[20:16];
  assign rd_idx  = instr[15:11];
  assign func    = instr[5:0];
  assign imm_ext = {{(WORD_W-16){instr[15]}}, instr[15:0]};
  assign unused_fields = ^instr[10:6];

  ctrl_t ctrl;
  rcore_ctrl u_ctrl (
    .opcode_i (opcode),
    .func_i   (func),
    .ctrl_o   (ctrl)
  );

  // Register file and write-back selection.
  logic [WORD_W-1:0] rs_val, rt_val, wb_val, alu_res, mem_rdata;
  logic [REG_AW-1:0] wb_idx;
  logic              reg_we;

  assign wb_idx = ctrl.dst_is_rd   ? rd_idx    : rt_idx;
  assign wb_val = ctrl.wb_from_mem ? mem_rdata : alu_res;
  assign reg_we = core_rst_n && ctrl.reg_write && (wb_idx != '0);

  rcore_regfile #(.NREGS(1 << REG_AW)) u_rf (
    .clk_i    (clk_i),
    .rst_n_i  (core_rst_n),
    .ra_idx_i (rs_idx),
    .rb_idx_i (rt_idx),
    .ra_val_o (rs_val),
    .rb_val_o (rt_val),
    .we_i     (reg_we),
    .w_idx_i  (wb_idx),
    .w_val_i  (wb_val)
  );

  // Execute.
  logic [WORD_W-1:0] alu_b;
  logic              alu_zero;
  assign alu_b    = ctrl.b_is_imm ? imm_ext : rt_val;
  assign br_taken = ctrl.is_branch && alu_zero;

  rcore_alu u_alu (
    .op_i   (ctrl.alu_op),
    .a_i    (rs_val),
    .b_i    (alu_b),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // Data memory.
  logic mem_we;
  assign mem_we = core_rst_n && ctrl.mem_write;

  rcore_dmem #(.WORDS(DMEM_WORDS), .INIT(DATA_INIT)) u_dmem (
    .clk_i   (clk_i),
    .rst_n_i (core_rst_n),
    .we_i    (mem_we),
    .idx_i   (alu_res[DAW+1:2]),
    .wdata_i (rt_val),
    .rdata_o (mem_rdata)
  );

  assign dbg_pc_o      = pc_q;
  assign dbg_wr_en_o   = reg_we;
  assign dbg_wr_idx_o  = wb_idx;
  assign dbg_wr_data_o = wb_val;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk
  import rcore_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              core_rst_n,
  input logic [WORD_W-1:0] pc,
  input logic [5:0]        opcode,
  input logic [5:0]        func,
  input logic              br_taken,
  input logic [WORD_W-1:0] imm_ext,
  input logic              reg_we,
  input logic [REG_AW-1:0] wb_idx,
  input logic              mem_we,
  input logic [REG_AW-1:0] rs_idx,
  input logic [WORD_W-1:0] rs_val
);

  logic known_op;
  always_comb begin
    known_op = (opcode == OPC_LOAD) || (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
               ((opcode == OPC_RTYPE) &&
                ((func == FN_ADD) || (func == FN_SUB) || (func == FN_AND) ||
                 (func == FN_OR)  || (func == FN_SLT)));
  end

  AST_RESET_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !core_rst_n |-> (pc == '0) && !reg_we); // R1

  AST_PC_SEQUENTIAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (core_rst_n && !br_taken) |=> pc == $past(pc) + WORD_W'(4)); // R2

  AST_BRANCH_TARGET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (core_rst_n && br_taken) |=>
      pc == $past(pc) + WORD_W'(4) + {$past(imm_ext[WORD_W-3:0]), 2'b00}); // R7

  AST_BRANCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (opcode == OPC_BEQ) |-> !reg_we && !mem_we); // R7

  AST_STORE_NO_REG: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (opcode == OPC_STORE) |-> !reg_we); // R6

  AST_ZERO_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rs_idx == '0) |-> (rs_val == '0)); // R9

  AST_ZERO_REG_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    reg_we |-> (wb_idx != '0)); // R9

  AST_UNKNOWN_NOP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !known_op |-> !reg_we && !mem_we); // R10

endmodule

bind rcore_top rcore_chk u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .core_rst_n (core_rst_n),
  .pc         (pc_q),
  .opcode     (opcode),
  .func       (func),
  .br_taken   (br_taken),
  .imm_ext    (imm_ext),
  .reg_we     (reg_we),
  .wb_idx     (wb_idx),
  .mem_we     (mem_we),
  .rs_idx     (rs_idx),
  .rs_val     (rs_val)
);

// File: tb/rcore_top_test.sv
`timescale 1ns/1ps
module rcore_top_test;

  localparam int IW = 32;
  localparam int DW = 16;
  localparam int NCODE = 24;
  localparam int NROWS = 22;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam logic [31:0] CODE [NCODE] = '{
    enc_i(6'h23, 5'd0, 5'd1, 16'd0),       // 0  load r1 <- word0
    enc_i(6'h23, 5'd0, 5'd2, 16'd4),       // 4  load r2 <- word1
    enc_i(6'h23, 5'd0, 5'd3, 16'd8),       // 8  load r3 <- word2
    enc_r(5'd1, 5'd2, 5'd4, 6'h20),        // 12 add
    enc_r(5'd1, 5'd2, 5'd5, 6'h22),        // 16 sub
    enc_r(5'd1, 5'd3, 5'd6, 6'h24),        // 20 and
    enc_r(5'd1, 5'd3, 5'd7, 6'h25),        // 24 or
    enc_r(5'd2, 5'd1, 5'd8, 6'h2A),        // 28 slt -3 < 7
    enc_r(5'd1, 5'd2, 5'd9, 6'h2A),        // 32 slt 7 < -3
    enc_i(6'h2B, 5'd0, 5'd5, 16'd20),      // 36 store r5 -> word5
    enc_i(6'h23, 5'd0, 5'd10, 16'd20),     // 40 load word5
    enc_r(5'd1, 5'd1, 5'd0, 6'h20),        // 44 write to r0
    enc_r(5'd0, 5'd0, 5'd11, 6'h20),       // 48 r11 = r0 + r0
    enc_i(6'h04, 5'd1, 5'd2, 16'd5),       // 52 beq unequal
    enc_i(6'h04, 5'd4, 5'd4, 16'd2),       // 56 beq equal, to 68
    enc_r(5'd1, 5'd1, 5'd12, 6'h20),       // 60 skipped
    enc_r(5'd1, 5'd1, 5'd12, 6'h20),       // 64 skipped
    enc_i(6'h08, 5'd0, 5'd13, 16'h0055),   // 68 unknown opcode
    enc_r(5'd1, 5'd1, 5'd14, 6'h00),       // 72 unknown function
    enc_i(6'h23, 5'd0, 5'd15, 16'hFFFC),   // 76 load, negative offset
    enc_i(6'h23, 5'd4, 5'd16, 16'd8),      // 80 load, base r4
    enc_i(6'h04, 5'd0, 5'd0, 16'd1),       // 84 beq to 92
    enc_r(5'd1, 5'd1, 5'd12, 6'h20),       // 88 skipped
    enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF)     // 92 backward to itself
  };

  function automatic logic [IW*32-1:0] pack_code();
    logic [IW*32-1:0] img = '0;
    for (int i = 0; i < NCODE; i++) img[i*32 +: 32] = CODE[i];
    return img;
  endfunction

  function automatic logic [DW*32-1:0] pack_data();
    logic [DW*32-1:0] img = '0;
    img[0*32 +: 32]  = 32'h0000_0007;
    img[1*32 +: 32]  = 32'hFFFF_FFFD;
    img[2*32 +: 32]  = 32'h0000_003C;
    img[3*32 +: 32]  = 32'h1234_5678;
    img[5*32 +: 32]  = 32'hDEAD_0005;
    img[15*32 +: 32] = 32'h5A5A_00F0;
    return img;
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic        wen;
    logic [4:0]  idx;
    logic [31:0] data;
  } row_t;

  // Expected state for each executed cycle after reset release.
  localparam row_t ROWS [NROWS] = '{
    '{32'd0,  1'b1, 5'd1,  32'h0000_0007},
    '{32'd4,  1'b1, 5'd2,  32'hFFFF_FFFD},
    '{32'd8,  1'b1, 5'd3,  32'h0000_003C},
    '{32'd12, 1'b1, 5'd4,  32'h0000_0004},
    '{32'd16, 1'b1, 5'd5,  32'h0000_000A},
    '{32'd20, 1'b1, 5'd6,  32'h0000_0004},
    '{32'd24, 1'b1, 5'd7,  32'h0000_003F},
    '{32'd28, 1'b1, 5'd8,  32'h0000_0001},
    '{32'd32, 1'b1, 5'd9,  32'h0000_0000},
    '{32'd36, 1'b0, 5'd0,  32'h0},
    '{32'd40, 1'b1, 5'd10, 32'h0000_000A},
    '{32'd44, 1'b0, 5'd0,  32'h0},
    '{32'd48, 1'b1, 5'd11, 32'h0000_0000},
    '{32'd52, 1'b0, 5'd0,  32'h0},
    '{32'd56, 1'b0, 5'd0,  32'h0},
    '{32'd68, 1'b0, 5'd0,  32'h0},
    '{32'd72, 1'b0, 5'd0,  32'h0},
    '{32'd76, 1'b1, 5'd15, 32'h5A5A_00F0},
    '{32'd80, 1'b1, 5'd16, 32'h1234_5678},
    '{32'd84, 1'b0, 5'd0,  32'h0},
    '{32'd92, 1'b0, 5'd0,  32'h0},
    '{32'd92, 1'b0, 5'd0,  32'h0}
  };

  function automatic string req_of(logic [31:0] pc);
    case (pc)
      32'd0, 32'd4, 32'd8:               return "R5 load";
      32'd12, 32'd16, 32'd20, 32'd24:    return "R3 arith/logic";
      32'd28, 32'd32:                    return "R4 signed compare";
      32'd36, 32'd40:                    return "R6 store then load";
      32'd44, 32'd48:                    return "R9 register zero";
      32'd52:                            return "R8 branch not taken";
      32'd56, 32'd84, 32'd92:            return "R7 branch taken";
      32'd68, 32'd72:                    return "R10 unknown encoding";
      32'd76, 32'd80:                    return "R5 load offset";
      default:                           return "R2 sequence";
    endcase
  endfunction

  logic        clk_i = 1'b0;
  logic        rst_n_i = 1'b0;
  logic [31:0] dbg_pc_o;
  logic        dbg_wr_en_o;
  logic [4:0]  dbg_wr_idx_o;
  logic [31:0] dbg_wr_data_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  rcore_top #(
    .IMEM_WORDS (IW),
    .DMEM_WORDS (DW),
    .IMAGE      (pack_code()),
    .DATA_INIT  (pack_data())
  ) uut (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .dbg_pc_o      (dbg_pc_o),
    .dbg_wr_en_o   (dbg_wr_en_o),
    .dbg_wr_idx_o  (dbg_wr_idx_o),
    .dbg_wr_data_o (dbg_wr_data_o)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 pc in reset", dbg_pc_o, 32'd0);
    chk("R1 no write in reset", {31'd0, dbg_wr_en_o}, 32'd0);
    rst_n_i = 1'b1;
    @(negedge clk_i);
    chk("R1 pc during release", dbg_pc_o, 32'd0);
    chk("R1 no write during release", {31'd0, dbg_wr_en_o}, 32'd0);
    @(negedge clk_i);

    // Program walk: one row per executed cycle.
    for (int i = 0; i < NROWS; i++) begin
      if (i == 15)      chk("R7 pc after taken forward branch", dbg_pc_o, ROWS[i].pc);
      else if (i == 14) chk("R8 pc after untaken branch", dbg_pc_o, ROWS[i].pc);
      else if (i >= 20) chk("R7 pc after branch", dbg_pc_o, ROWS[i].pc);
      else              chk("R2 pc", dbg_pc_o, ROWS[i].pc);
      chk({req_of(ROWS[i].pc), " write enable"}, {31'd0, dbg_wr_en_o}, {31'd0, ROWS[i].wen});
      if (ROWS[i].wen) begin
        chk({req_of(ROWS[i].pc), " write index"}, {27'd0, dbg_wr_idx_o}, {27'd0, ROWS[i].idx});
        chk({req_of(ROWS[i].pc), " write data"}, dbg_wr_data_o, ROWS[i].data);
      end
      @(negedge clk_i);
    end

    // R1: reset in the middle of the run restarts at address 0.
    rst_n_i = 1'b0;
    #1;
    chk("R1 pc right after reset assert", dbg_pc_o, 32'd0);
    chk("R1 no write right after reset assert", {31'd0, dbg_wr_en_o}, 32'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_n_i = 1'b1;
    @(negedge clk_i);
    chk("R1 still held one edge after release", {31'd0, dbg_wr_en_o}, 32'd0);
    @(negedge clk_i);
    chk("R1 restart pc", dbg_pc_o, 32'd0);
    chk("R1 restart write enable", {31'd0, dbg_wr_en_o}, 32'd1);
    chk("R1 restart write data", dbg_wr_data_o, 32'h0000_0007);
    @(negedge clk_i);
    chk("R2 pc after restart", dbg_pc_o, 32'd4);

    finish_run();
  end

endmodule